// File: doc/BRIEF.md
# Single-Word Access Adapter for a Two-Beat Double-Rate Data Path

This block lets a client that works one word at a time use a double-data-rate memory. Such a memory transfers data on both clock edges and offers no burst length of one. The client issues a read or a write of one word. The adapter turns that request into the shortest burst the memory allows: one clock, which carries two beats. The column address goes out unchanged, including its low bit. The memory therefore returns or accepts the addressed word in the first beat, and its even/odd partner in the second beat.

For a write, the client word is placed on the first beat. Every byte-mask bit of the second beat is asserted, so the partner word is left as it was. For a read, the adapter collects both returned beats and hands back only the first. It can also be built for a memory programmed with a longer burst. In that case it cuts the burst short with a stop command on the cycle after the burst command.

The adapter handles one request at a time. A handshake signal tells the client when a new request may be presented.

Top module: `dsw_adapter`

## Requirements
- R1: While reset is held, `req_ready` is 1 and `cmd_valid`, `cmd_stop`, `wr_valid` and `rsp_valid` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 from the next cycle onward. It returns to 1 in the cycle after the write-beat cycle, or in the cycle after the read response.
- R3: In the cycle after acceptance, `cmd_valid` is 1 for exactly one cycle. In that cycle `cmd_write` equals the request's write flag and `cmd_col` equals the request address with its low bit unchanged.
- R4: For a write, `wr_valid` is 1 for exactly one cycle, the cycle after the command. In that cycle `wr_data0` carries the write word and `wr_mask0` is all zeros.
- R5: In the write-beat cycle every bit of `wr_mask1` is 1 and `wr_data1` is zero. A mask bit of 1 means that byte is not stored.
- R6: For a read, the adapter captures the beats presented with `rd_beat_valid` in the cycles after the command, in any spacing. `rsp_valid` is 1 for exactly one cycle: the cycle after the second beat is captured.
- R7: `rsp_data` in the response cycle equals the first captured beat. The second beat never reaches the client.
- R8: When `BURST_BEATS` is greater than 2, `cmd_stop` is 1 for exactly the cycle after each command. When it is 2, `cmd_stop` stays 0. Only 2, 4 and 8 are legal values.
- R9: `req_valid` is ignored while `req_ready` is 0. No extra command is issued and the active access finishes normally.
- R10: `rd_beat_valid` is ignored when no read is waiting for beats. Stray beats produce no response and do not disturb the next read.
- R11: At the system level, with a memory that keeps masked bytes, a single-word write to an even or an odd address changes only that word. A later read of that word returns the new value, and a read of its partner returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Client request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word (column) address |
| req_wdata | input | DATA_W | Write word |
| req_ready | output | 1 | Adapter idle and able to take a request |
| cmd_valid | output | 1 | Burst command strobe |
| cmd_write | output | 1 | Burst direction, 1 = write |
| cmd_col | output | ADDR_W | Burst start column, low bit included |
| cmd_stop | output | 1 | Burst-cut command (longer programmed bursts only) |
| wr_valid | output | 1 | Write beats valid |
| wr_data0 | output | DATA_W | First write beat (addressed word) |
| wr_data1 | output | DATA_W | Second write beat (partner, masked) |
| wr_mask0 | output | DATA_W/8 | Byte mask for first beat, 1 = not stored |
| wr_mask1 | output | DATA_W/8 | Byte mask for second beat, 1 = not stored |
| rd_beat_valid | input | 1 | A returned read beat is present |
| rd_beat_data | input | DATA_W | Returned read beat |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | DATA_W | Read response word |

## Verification
Some rules are checked by the assertions on every cycle. These are the one-cycle width of the command, write-beat and response strobes, and `req_ready` being low while a command is out. They also cover the ordering of each strobe: write beats follow a write command, a response follows a captured beat, and a stop follows a command. Other behaviour only the bench scenarios can show. This includes which beat carries the data and which mask bits are set, how odd and even addresses behave, and that busy-time requests and stray beats are ignored. Above all, only the bench's memory model can show that the partner word survives a write.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ISSUE  = 3'd1,
    ST_WBEAT  = 3'd2,
    ST_RBEAT0 = 3'd3,
    ST_RBEAT1 = 3'd4,
    ST_RESP   = 3'd5
  } dsw_state_e;

  // A programmed burst longer than one clock must be cut short.
  function automatic bit burst_needs_stop(input int beats);
    return beats > 2;
  endfunction

  // Index of the returned beat that holds the addressed word.
  localparam int unsigned WANTED_BEAT = 0;

endpackage

// File: rtl/dsw_ctrl.sv
module dsw_ctrl
  import dsw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_beat_valid,
  output logic              req_ready,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_col,
  output logic              wbeat_en,
  output logic [DATA_W-1:0] wdata_q,
  output logic              cap_en,
  output logic              cap_idx,
  output logic              rsp_fire
);

  dsw_state_e        state_q, state_d;
  logic              load_en;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;

  assign load_en = (state_q == ST_IDLE) && req_valid;

  // Next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_ISSUE;
      ST_ISSUE:  state_d = write_q ? ST_WBEAT : ST_RBEAT0;
      ST_WBEAT:  state_d = ST_IDLE;
      ST_RBEAT0: if (rd_beat_valid) state_d = ST_RBEAT1;
      ST_RBEAT1: if (rd_beat_valid) state_d = ST_RESP;
      ST_RESP:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Request hold registers, loaded on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign cmd_valid = (state_q == ST_ISSUE);
  assign cmd_write = write_q;
  assign cmd_col   = addr_q;
  assign wbeat_en  = (state_q == ST_WBEAT);
  assign cap_en    = (state_q == ST_RBEAT0) || (state_q == ST_RBEAT1);
  assign cap_idx   = (state_q == ST_RBEAT1);
  assign rsp_fire  = (state_q == ST_RESP);

  assert_cmd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid) else $error("command strobe longer than one cycle");

  assert_busy_during_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready) else $error("ready high while command out");

  assert_accept_to_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cmd_valid) else $error("accepted request gave no command");

  assert_wbeat_after_wcmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wbeat_en |-> $past(cmd_valid && cmd_write)) else $error("write beats without write command");

  assert_ready_after_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> req_ready) else $error("not idle after response");

endmodule

// File: rtl/dsw_wr_lane.sv
module dsw_wr_lane #(
  parameter int DATA_W = 32
) (
  input  logic                  wbeat_en,
  input  logic [DATA_W-1:0]     wdata,
  output logic                  wr_valid,
  output logic [DATA_W-1:0]     wr_data0,
  output logic [DATA_W-1:0]     wr_data1,
  output logic [DATA_W/8-1:0]   wr_mask0,
  output logic [DATA_W/8-1:0]   wr_mask1
);

  localparam int BYTES = DATA_W / 8;

  assign wr_valid = wbeat_en;

  // Per-byte lanes: addressed beat stores every byte, partner beat none.
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign wr_data0[8*b +: 8] = wbeat_en ? wdata[8*b +: 8] : 8'h00;
    assign wr_data1[8*b +: 8] = 8'h00;
    assign wr_mask0[b]        = 1'b0;
    assign wr_mask1[b]        = 1'b1;
  end

endmodule

// File: rtl/dsw_rd_capture.sv
module dsw_rd_capture
  import dsw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              cap_idx,
  input  logic              rd_beat_valid,
  input  logic [DATA_W-1:0] rd_beat_data,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int BEATS = 2;

  logic [DATA_W-1:0] beat_q [BEATS];

  for (genvar i = 0; i < BEATS; i++) begin : g_beat
    logic beat_ce;
    assign beat_ce = cap_en && rd_beat_valid && (cap_idx == 1'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       beat_q[i] <= '0;
      else if (beat_ce) beat_q[i] <= rd_beat_data;
    end
  end

  assign rsp_data = beat_q[WANTED_BEAT];

endmodule

// File: rtl/dsw_stop_gen.sv
module dsw_stop_gen
  import dsw_pkg::*;
#(
  parameter int BURST_BEATS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  output logic cmd_stop
);

  if (burst_needs_stop(BURST_BEATS)) begin : g_cut
    logic stop_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stop_q <= 1'b0;
      else        stop_q <= cmd_valid;
    end
    assign cmd_stop = stop_q;

    assert_stop_after_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop |-> $past(cmd_valid)) else $error("stop without preceding command");

    assert_stop_follows_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> cmd_stop) else $error("command not cut short");
  end else begin : g_min
    assign cmd_stop = 1'b0;
  end

endmodule

// File: rtl/dsw_adapter.sv
module dsw_adapter #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int BURST_BEATS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  req_ready,
  output logic                  cmd_valid,
  output logic                  cmd_write,
  output logic [ADDR_W-1:0]     cmd_col,
  output logic                  cmd_stop,
  output logic                  wr_valid,
  output logic [DATA_W-1:0]     wr_data0,
  output logic [DATA_W-1:0]     wr_data1,
  output logic [DATA_W/8-1:0]   wr_mask0,
  output logic [DATA_W/8-1:0]   wr_mask1,
  input  logic                  rd_beat_valid,
  input  logic [DATA_W-1:0]     rd_beat_data,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_data
);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic              wbeat_en;
  logic [DATA_W-1:0] wdata_q;
  logic              cap_en;
  logic              cap_idx;
  logic              rsp_fire;

  dsw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rd_beat_valid (rd_beat_valid),
    .req_ready     (req_ready),
    .cmd_valid     (cmd_valid),
    .cmd_write     (cmd_write),
    .cmd_col       (cmd_col),
    .wbeat_en      (wbeat_en),
    .wdata_q       (wdata_q),
    .cap_en        (cap_en),
    .cap_idx       (cap_idx),
    .rsp_fire      (rsp_fire)
  );

  dsw_wr_lane #(.DATA_W(DATA_W)) u_wr_lane (
    .wbeat_en (wbeat_en),
    .wdata    (wdata_q),
    .wr_valid (wr_valid),
    .wr_data0 (wr_data0),
    .wr_data1 (wr_data1),
    .wr_mask0 (wr_mask0),
    .wr_mask1 (wr_mask1)
  );

  dsw_rd_capture #(.DATA_W(DATA_W)) u_rd_capture (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .cap_en        (cap_en),
    .cap_idx       (cap_idx),
    .rd_beat_valid (rd_beat_valid),
    .rd_beat_data  (rd_beat_data),
    .rsp_data      (rsp_data)
  );

  dsw_stop_gen #(.BURST_BEATS(BURST_BEATS)) u_stop_gen (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cmd_valid (cmd_valid),
    .cmd_stop  (cmd_stop)
  );

  assign rsp_valid = rsp_fire;

  assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |=> !rsp_valid) else $error("response longer than one cycle");

  assert_rsp_after_beat_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |-> $past(rd_beat_valid)) else $error("response without captured beat");

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_valid |=> !wr_valid) else $error("write beats longer than one cycle");

  assert_wr_partner_masked_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_valid |-> ($countones(wr_mask1) == DATA_W/8)) else $error("partner beat not masked");

  assert_no_cmd_while_wbeat_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_valid |-> !cmd_valid) else $error("command overlaps write beats");

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({cmd_valid, wr_valid, rsp_valid})) else $error("strobes overlap");

endmodule

// File: tb/dsw_adapter_tb_top.sv
`timescale 1ns/1ps
module dsw_adapter_tb_top;

  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int NB    = DW / 8;
  localparam int TB_BL = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, cmd_valid, cmd_write, cmd_stop, wr_valid;
  logic [AW-1:0] cmd_col;
  logic [DW-1:0] wr_data0, wr_data1, rd_beat_data, rsp_data;
  logic [NB-1:0] wr_mask0, wr_mask1;
  logic          rd_beat_valid, rsp_valid;

  always #4 clk = ~clk;

  dsw_adapter #(.ADDR_W(AW), .DATA_W(DW), .BURST_BEATS(TB_BL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col), .cmd_stop(cmd_stop),
    .wr_valid(wr_valid), .wr_data0(wr_data0), .wr_data1(wr_data1),
    .wr_mask0(wr_mask0), .wr_mask1(wr_mask1),
    .rd_beat_valid(rd_beat_valid), .rd_beat_data(rd_beat_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Memory model: 16-word window, masked bytes left unchanged
  logic [DW-1:0] mem [16];

  // Behavioural cycle model: 0 idle, 1 command, 2 write beats, 3 waiting beats, 4 response
  int            mphase = 0;
  int            mcnt   = 0;
  bit            mwrite = 1'b0;
  logic [AW-1:0] maddr  = '0;

  always @(negedge clk) begin
    int old;
    old = mphase;
    if (!rst_n) begin
      mphase = 0;
      mcnt   = 0;
    end else begin
      case (mphase)
        0: if (req_valid) begin mphase = 1; mwrite = req_write; maddr = req_addr; end
        1: begin mphase = mwrite ? 2 : 3; mcnt = 0; end
        2: mphase = 0;
        3: if (rd_beat_valid) begin mcnt++; if (mcnt == 2) mphase = 4; end
        4: mphase = 0;
        default: mphase = 0;
      endcase
      check(req_ready == (mphase == 0), "R2 ready", 64'(req_ready), 64'(mphase == 0));
      check(cmd_valid == (mphase == 1), "R3/R9 command strobe", 64'(cmd_valid), 64'(mphase == 1));
      check(wr_valid  == (mphase == 2), "R4 write strobe", 64'(wr_valid), 64'(mphase == 2));
      check(rsp_valid == (mphase == 4), "R6/R10 response strobe", 64'(rsp_valid), 64'(mphase == 4));
      check(cmd_stop == ((TB_BL > 2) && (old == 1)), "R8 stop", 64'(cmd_stop), 64'((TB_BL > 2) && (old == 1)));
      if (mphase == 2 && wr_valid) begin
        for (int b = 0; b < NB; b++) begin
          if (!wr_mask0[b]) mem[maddr[3:0]][8*b +: 8] = wr_data0[8*b +: 8];
          if (!wr_mask1[b]) mem[maddr[3:0] ^ 4'd1][8*b +: 8] = wr_data1[8*b +: 8];
        end
      end
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke_busy);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    check(cmd_write == 1'b1, "R3 write flag", 64'(cmd_write), 64'd1);
    check(cmd_col == a, "R3 column with low bit", 64'(cmd_col), 64'(a));
    #1;
    if (poke_busy) begin
      req_valid = 1'b1; req_write = 1'b0; req_addr = a ^ 10'h2A5; req_wdata = ~d;
    end else req_valid = 1'b0;
    @(negedge clk);
    check(wr_data0 == d, "R4 beat0 data", 64'(wr_data0), 64'(d));
    check(wr_mask0 == '0, "R4 beat0 mask", 64'(wr_mask0), 64'd0);
    check(wr_mask1 == '1, "R5 beat1 mask", 64'(wr_mask1), 64'({NB{1'b1}}));
    check(wr_data1 == '0, "R5 beat1 data", 64'(wr_data1), 64'd0);
    if (poke_busy) check(cmd_valid == 1'b0, "R9 no extra command", 64'(cmd_valid), 64'd0);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input int gap, input string req);
    logic [DW-1:0] b0, b1;
    b0 = mem[a[3:0]];
    b1 = mem[a[3:0] ^ 4'd1];
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
    @(negedge clk);
    check(cmd_write == 1'b0, "R3 read flag", 64'(cmd_write), 64'd0);
    check(cmd_col == a, "R3 read column", 64'(cmd_col), 64'(a));
    #1 req_valid = 1'b0;
    @(negedge clk); #1;
    rd_beat_valid = 1'b1; rd_beat_data = b0;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); #1;
      rd_beat_valid = 1'b0; rd_beat_data = 32'hDEAD_0000;
    end
    @(negedge clk); #1;
    rd_beat_valid = 1'b1; rd_beat_data = b1;
    @(negedge clk);
    check(rsp_valid == 1'b1, "R6 response strobe", 64'(rsp_valid), 64'd1);
    check(rsp_data == b0, "R7 first beat selected", 64'(rsp_data), 64'(b0));
    check(rsp_data == exp, req, 64'(rsp_data), 64'(exp));
    #1 rd_beat_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R2/R6 back to idle", 64'({rsp_valid, req_ready}), 64'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] init4, init5, init6, init7;
    for (int i = 0; i < 16; i++) mem[i] = 32'hA500_0000 + 32'(i) * 32'h0101_0101;
    init4 = mem[4]; init5 = mem[5]; init6 = mem[6]; init7 = mem[7];
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rd_beat_valid = 1'b0; rd_beat_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
    check({cmd_valid, cmd_stop, wr_valid, rsp_valid} == 4'b0, "R1 strobes in reset",
          64'({cmd_valid, cmd_stop, wr_valid, rsp_valid}), 64'd0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 even address write, partner untouched
    do_write(10'd4, 32'h1234_5678, 1'b0);
    do_read(10'd4, 32'h1234_5678, 0, "R11 even word updated");
    do_read(10'd5, init5, 0, "R11 odd partner untouched");

    // R11 odd address write: wrapped order, even partner untouched
    do_write(10'd7, 32'hCAFE_F00D, 1'b0);
    do_read(10'd7, 32'hCAFE_F00D, 2, "R11 odd word updated");
    do_read(10'd6, init6, 1, "R11 even partner untouched");
    check(mem[4] == 32'h1234_5678, "R11 earlier word kept", 64'(mem[4]), 64'h1234_5678);

    // R9 request held during busy write is ignored
    do_write(10'd9, 32'hFFFF_FFFF, 1'b1);
    @(negedge clk);
    check(cmd_valid == 1'b0, "R9 no late command", 64'(cmd_valid), 64'd0);
    do_read(10'd9, 32'hFFFF_FFFF, 0, "R9 busy write completed");
    do_read(10'd8, 32'hA500_0000 + 32'd8 * 32'h0101_0101, 0, "R11 partner of 9 untouched");

    // R10 stray beats while idle are ignored
    @(negedge clk); #1;
    rd_beat_valid = 1'b1; rd_beat_data = 32'hBAD0_BAD0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 stray beat no response", 64'(rsp_valid), 64'd0);
    #1 rd_beat_data = 32'hBAD1_BAD1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 second stray beat", 64'(rsp_valid), 64'd0);
    #1 rd_beat_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 still no response", 64'(rsp_valid), 64'd0);
    do_read(10'd4, 32'h1234_5678, 0, "R10 next read unaffected");

    // zero data write on odd address followed by reads of both
    do_write(10'd3, 32'h0000_0000, 1'b0);
    do_read(10'd3, 32'h0000_0000, 0, "R11 zero word stored");
    do_read(10'd2, 32'hA500_0000 + 32'd2 * 32'h0101_0101, 0, "R11 partner of 3 untouched");
    check(mem[5] == init5 && mem[6] == init6, "R11 no spill", 64'({mem[5], mem[6]}), 64'({init5, init6}));
    check(init4 != init7, "R11 distinct preload", 64'(init4), 64'(init7));

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule